// File: doc/BRIEF.md
# Temperature Threshold Alarm Register Slice

This block is the register-mapped front end of one temperature comparator. Software programs a signed threshold, a comparison direction and an interrupt enable. Each time the sensor path delivers a new 16-bit signed temperature sample, the block keeps the sample and compares it against the threshold. When the comparison holds, the block raises a sticky alarm flag. The interrupt line is asserted while that flag is set and the enable is on. Samples and thresholds share one scale: two's complement in steps of 1/64 °C.

Every writable register sits in a group of four consecutive word addresses, and the group is selected by address bits 5:4. Inside a group, address bits 3:2 choose the update: a plain write (+0x0), an OR-in (+0x4), a clear of the written ones (+0x8) or an invert of the written ones (+0xC). The bus completes in a single cycle. A write takes effect at the clock edge, and the read data is a combinational function of the address. The sample input is a valid/ready stream. Ready is held high at all times, so the producer never sees back-pressure, and every cycle with valid high delivers exactly one sample.

Top module: `thermal_alarm`

## Requirements
- R1: The control group (0x00–0x0C) retains only the enable at bit 9 and the mode at bits 3:2. The threshold group (0x30–0x3C) retains only bits 31:16. All other bits read 0. Offsets +0x0, +0x4, +0x8 and +0xC replace the register, OR the data in, clear the written ones and invert the written ones.
- R2: After reset, every register reads 0 and `irq` is low.
- R3: `smp_ready` is always 1. A sample accepted in one cycle reads back at 0x20 from the next cycle, sign-extended to 32 bits. The last of several back-to-back samples is the one kept.
- R4: Mode 0 is true when the sample is less than or equal to the threshold, compared as signed numbers. Mode 1 is true when the sample is greater than or equal to the threshold, also signed. The live result is shown at status bit 13 (status at 0x10) and is updated by every accepted sample.
- R5: Mode values 2 and 3 never make the comparison true.
- R6: The alarm flag at status bit 9 sets on any accepted sample whose comparison is true. It stays set after later samples compare false.
- R7: Only a write of 1 to bit 9 at the status clear address 0x18 clears the alarm flag. Writes at 0x10, 0x14 and 0x1C leave the status unchanged. If a sample sets the flag in the same cycle as a clear, the set wins.
- R8: Status bit 16 sets on every accepted sample. Writing 1 to bit 16 at 0x18 clears it.
- R9: `irq` is high exactly when the alarm flag and the enable are both 1.
- R10: Writing a 1 to control bit 21 through any control address clears the live result (status bit 13). It leaves the alarm flag alone and is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Byte address, word aligned |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| smp_valid | input | 1 | Sample valid |
| smp_ready | output | 1 | Sample ready, always 1 |
| smp_data | input | 16 | Signed temperature sample, 1/64 °C |
| irq | output | 1 | Alarm interrupt |

## Verification
The checker watches several properties on every cycle. An accepted sample must appear in the data register and set the data-ready flag one cycle later. Reserved modes must never produce a live result. The alarm flag must survive every cycle that has no clear strobe, and a clear strobe must drop the flag when no sample arrives alongside it. A fault-clear write must drop the live result, and `irq` must never rise without both the flag and the enable. The bench scenarios cover what no single-cycle property can show: the signed comparison at equality and across the sign boundary, the bit-exact results of the four update aliases, writes to status that have no effect, and a set that wins against a clear in the same cycle.

// File: rtl/thermal_alarm_pkg.sv
package thermal_alarm_pkg;
  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_SET    = 2'd1,
    OP_CLEAR  = 2'd2,
    OP_TOGGLE = 2'd3
  } alias_op_e;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_DATA = 2'd2,
    SEL_THR  = 2'd3
  } reg_sel_e;

  localparam int IE_BIT      = 9;
  localparam int MODE_LO     = 2;
  localparam int FLT_CLR_BIT = 21;
  localparam int FLAG_BIT    = 9;
  localparam int LIVE_BIT    = 13;
  localparam int DRDY_BIT    = 16;

  function automatic logic [31:0] alias_apply(input logic [31:0] cur,
                                              input logic [31:0] wd,
                                              input alias_op_e   op);
    case (op)
      OP_WRITE:  return wd;
      OP_SET:    return cur | wd;
      OP_CLEAR:  return cur & ~wd;
      default:   return cur ^ wd;
    endcase
  endfunction
endpackage

// File: rtl/alarm_bus_decode.sv
module alarm_bus_decode
  import thermal_alarm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic              hit,
  output reg_sel_e          rsel,
  output alias_op_e         op,
  output logic              wr_ctrl,
  output logic              wr_stat,
  output logic              wr_thr
);
  localparam int HI_W = ADDR_W - 6;

  always_comb begin
    hit     = (addr[ADDR_W-1:6] == {HI_W{1'b0}}) && (addr[1:0] == 2'b00);
    rsel    = reg_sel_e'(addr[5:4]);
    op      = alias_op_e'(addr[3:2]);
    wr_ctrl = wr && hit && (rsel == SEL_CTRL);
    wr_stat = wr && hit && (rsel == SEL_STAT);
    wr_thr  = wr && hit && (rsel == SEL_THR);
  end
endmodule

// File: rtl/alarm_cfg_regs.sv
module alarm_cfg_regs
  import thermal_alarm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SMP_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_thr,
  input  alias_op_e         op,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] thr_q,
  output logic              ie,
  output logic [1:0]        mode,
  output logic [SMP_W-1:0]  thr
);
  localparam int THR_LO = DATA_W - SMP_W;
  localparam logic [DATA_W-1:0] CTRL_MASK =
    (DATA_W'(1) << IE_BIT) | (DATA_W'(3) << MODE_LO);
  localparam logic [DATA_W-1:0] THR_MASK =
    {{SMP_W{1'b1}}, {THR_LO{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      thr_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= alias_apply(ctrl_q, wdata, op) & CTRL_MASK;
      if (wr_thr)  thr_q  <= alias_apply(thr_q, wdata, op) & THR_MASK;
    end
  end

  assign ie   = ctrl_q[IE_BIT];
  assign mode = ctrl_q[MODE_LO +: 2];
  assign thr  = thr_q[THR_LO +: SMP_W];
endmodule

// File: rtl/alarm_compare.sv
module alarm_compare #(
  parameter int SMP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  input  logic [1:0]       mode,
  input  logic [SMP_W-1:0] thr,
  input  logic             fault_clr,
  input  logic             clr_flag,
  input  logic             clr_drdy,
  output logic             live_q,
  output logic             flag_q,
  output logic             drdy_q,
  output logic [SMP_W-1:0] data_q
);
  logic hit_now;

  always_comb begin
    case (mode)
      2'd0:    hit_now = $signed(smp_data) <= $signed(thr);
      2'd1:    hit_now = $signed(smp_data) >= $signed(thr);
      default: hit_now = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      flag_q <= 1'b0;
      drdy_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (smp_valid) begin
        data_q <= smp_data;
        live_q <= hit_now;
      end else if (fault_clr) begin
        live_q <= 1'b0;
      end
      if (smp_valid && hit_now) flag_q <= 1'b1;
      else if (clr_flag)        flag_q <= 1'b0;
      if (smp_valid)            drdy_q <= 1'b1;
      else if (clr_drdy)        drdy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/thermal_alarm.sv
module thermal_alarm
  import thermal_alarm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SMP_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [SMP_W-1:0]  smp_data,
  output logic              irq
);
  localparam int EXT_W = DATA_W - SMP_W;

  logic              hit, wr_ctrl, wr_stat, wr_thr;
  reg_sel_e          rsel;
  alias_op_e         op;
  logic [DATA_W-1:0] ctrl_q, thr_q;
  logic              ie_q;
  logic [1:0]        mode_q;
  logic [SMP_W-1:0]  thr_val;
  logic              live_q, flag_q, drdy_q;
  logic [SMP_W-1:0]  data_q;
  logic              fault_clr, clr_flag, clr_drdy;

  alarm_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(reg_addr), .wr(reg_wr), .hit(hit), .rsel(rsel), .op(op),
    .wr_ctrl(wr_ctrl), .wr_stat(wr_stat), .wr_thr(wr_thr)
  );

  alarm_cfg_regs #(.DATA_W(DATA_W), .SMP_W(SMP_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_thr(wr_thr), .op(op),
    .wdata(reg_wdata), .ctrl_q(ctrl_q), .thr_q(thr_q), .ie(ie_q),
    .mode(mode_q), .thr(thr_val)
  );

  assign fault_clr = wr_ctrl && reg_wdata[FLT_CLR_BIT];
  assign clr_flag  = wr_stat && (op == OP_CLEAR) && reg_wdata[FLAG_BIT];
  assign clr_drdy  = wr_stat && (op == OP_CLEAR) && reg_wdata[DRDY_BIT];

  alarm_compare #(.SMP_W(SMP_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .mode(mode_q), .thr(thr_val), .fault_clr(fault_clr),
    .clr_flag(clr_flag), .clr_drdy(clr_drdy),
    .live_q(live_q), .flag_q(flag_q), .drdy_q(drdy_q), .data_q(data_q)
  );

  always_comb begin
    reg_rdata = '0;
    if (hit) begin
      case (rsel)
        SEL_CTRL: reg_rdata = ctrl_q;
        SEL_STAT: begin
          reg_rdata[FLAG_BIT] = flag_q;
          reg_rdata[LIVE_BIT] = live_q;
          reg_rdata[DRDY_BIT] = drdy_q;
        end
        SEL_DATA: reg_rdata = {{EXT_W{data_q[SMP_W-1]}}, data_q};
        default:  reg_rdata = thr_q;
      endcase
    end
  end

  assign smp_ready = 1'b1;
  assign irq       = flag_q & ie_q;
endmodule

// File: rtl/thermal_alarm_chk.sv
module thermal_alarm_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SMP_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              smp_valid,
  input logic [SMP_W-1:0]  smp_data,
  input logic              irq,
  input logic              ie_q,
  input logic [1:0]        mode_q,
  input logic              live_q,
  input logic              flag_q,
  input logic              drdy_q,
  input logic [SMP_W-1:0]  data_q
);
  logic stat_clr_flag, ctrl_fault;
  assign stat_clr_flag = reg_wr && (reg_addr == ADDR_W'(8'h18)) && reg_wdata[9];
  assign ctrl_fault    = reg_wr && (reg_addr[ADDR_W-1:4] == '0) &&
                         (reg_addr[1:0] == 2'b00) && reg_wdata[21];

  p_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> data_q == $past(smp_data));
  p_resv_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && mode_q[1]) |=> !live_q);
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !stat_clr_flag) |=> flag_q);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr_flag && !smp_valid) |=> !flag_q);
  p_drdy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> drdy_q);
  p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (flag_q && ie_q));
  p_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_fault && !smp_valid) |=> !live_q);
endmodule

bind thermal_alarm thermal_alarm_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SMP_W(SMP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .smp_valid(smp_valid), .smp_data(smp_data),
  .irq(irq), .ie_q(ie_q), .mode_q(mode_q), .live_q(live_q),
  .flag_q(flag_q), .drdy_q(drdy_q), .data_q(data_q)
);

// File: tb/thermal_alarm_tb_top.sv
module thermal_alarm_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;
  // {mode[1:0], threshold[15:0], sample[15:0], expected hit}
  localparam logic [34:0] VEC [NVEC] = '{
    {2'd0, 16'h0640, 16'h0640, 1'b1},
    {2'd0, 16'h0640, 16'h0641, 1'b0},
    {2'd0, 16'hFD80, 16'hFD00, 1'b1},
    {2'd0, 16'h0000, 16'h0001, 1'b0},
    {2'd1, 16'h0640, 16'h0640, 1'b1},
    {2'd1, 16'h0640, 16'h063F, 1'b0},
    {2'd1, 16'hFF00, 16'h0010, 1'b1},
    {2'd1, 16'h0010, 16'hFF00, 1'b0},
    {2'd2, 16'h0000, 16'h0000, 1'b0},
    {2'd3, 16'h7FFF, 16'h8000, 1'b0},
    {2'd0, 16'h7FFF, 16'h8000, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [15:0] smp_data = '0;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermal_alarm dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_data(smp_data), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic sample(input logic [15:0] s);
    @(negedge clk); smp_data = s; smp_valid = 1'b1;
    @(negedge clk); smp_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3 + 2) rst_n = 1'b1;
    // R2 reset state
    rd(8'h00, rv); check("R2 ctrl", rv, 32'h0);
    rd(8'h10, rv); check("R2 status", rv, 32'h0);
    rd(8'h20, rv); check("R2 data", rv, 32'h0);
    rd(8'h30, rv); check("R2 thr", rv, 32'h0);
    check("R2 irq", {31'b0, irq}, 32'h0);
    check("R3 ready", {31'b0, smp_ready}, 32'h1);

    // vector table: R4 R5 R6 R9
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0]  m;
      logic [15:0] t, s;
      logic        h;
      {m, t, s, h} = VEC[i];
      wr(8'h00, (32'h1 << 9) | ({30'b0, m} << 2));
      wr(8'h30, {t, 16'h0});
      wr(8'h18, 32'h0001_0200);
      sample(s);
      rd(8'h10, rv);
      check("R4 live", {31'b0, rv[13]}, {31'b0, h});
      check("R6 flag", {31'b0, rv[9]}, {31'b0, h});
      check("R9 irq", {31'b0, irq}, {31'b0, h});
      rd(8'h20, rv); check("R3 data", rv, {{16{s[15]}}, s});
    end

    // R1 alias operations
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, rv); check("R1 ctrl write", rv, 32'h0000_020C);
    wr(8'h08, 32'h0000_0200); rd(8'h00, rv); check("R1 ctrl clear", rv, 32'h0000_000C);
    wr(8'h0C, 32'h0000_0204); rd(8'h00, rv); check("R1 ctrl toggle", rv, 32'h0000_0208);
    wr(8'h04, 32'h0000_0004); rd(8'h00, rv); check("R1 ctrl set", rv, 32'h0000_020C);
    wr(8'h30, 32'h1234_ABCD); rd(8'h30, rv); check("R1 thr write", rv, 32'h1234_0000);
    wr(8'h34, 32'h0001_0000); rd(8'h30, rv); check("R1 thr set", rv, 32'h1235_0000);
    wr(8'h38, 32'h1000_0000); rd(8'h30, rv); check("R1 thr clear", rv, 32'h0235_0000);
    wr(8'h3C, 32'hFFFF_0000); rd(8'h30, rv); check("R1 thr toggle", rv, 32'hFDCA_0000);

    // R6 / R9 sticky flag with enable off then on
    wr(8'h00, 32'h0000_0004);            // mode 1, ie 0
    wr(8'h30, 32'h0100_0000);
    wr(8'h18, 32'h0001_0200);
    sample(16'h0200);
    rd(8'h10, rv); check("R6 set", rv, 32'h0001_2200);
    check("R9 irq masked", {31'b0, irq}, 32'h0);
    sample(16'h0050);
    rd(8'h10, rv); check("R6 sticky", rv, 32'h0001_0200);
    wr(8'h04, 32'h0000_0200);
    check("R9 irq enabled", {31'b0, irq}, 32'h1);

    // R7 ignored status writes
    wr(8'h10, 32'h0);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h1C, 32'h0001_0200);
    rd(8'h10, rv); check("R7 ignored writes", rv, 32'h0001_0200);
    wr(8'h18, 32'h0000_0200);
    rd(8'h10, rv); check("R7 cleared", rv, 32'h0001_0000);
    check("R9 irq dropped", {31'b0, irq}, 32'h0);
    wr(8'h18, 32'h0001_0000);
    rd(8'h10, rv); check("R8 drdy cleared", rv, 32'h0);

    // R10 fault clear
    sample(16'h0200);
    wr(8'h04, 32'h0020_0000);
    rd(8'h10, rv); check("R10 live cleared", rv, 32'h0001_0200);
    rd(8'h00, rv); check("R10 not stored", rv, 32'h0000_0204);

    // R7 set beats clear in the same cycle
    @(negedge clk);
    reg_addr = 8'h18; reg_wdata = 32'h0000_0200; reg_wr = 1'b1;
    smp_data = 16'h0300; smp_valid = 1'b1;
    @(negedge clk); reg_wr = 1'b0; smp_valid = 1'b0;
    rd(8'h10, rv); check("R7 set wins", {31'b0, rv[9]}, 32'h1);

    // R3 back-to-back samples, R8 drdy
    wr(8'h18, 32'h0001_0000);
    @(negedge clk); smp_data = 16'h1111; smp_valid = 1'b1;
    @(negedge clk); smp_data = 16'hF00D;
    @(negedge clk); smp_valid = 1'b0;
    rd(8'h20, rv); check("R3 last sample", rv, 32'hFFFF_F00D);
    rd(8'h10, rv); check("R8 drdy set", {31'b0, rv[16]}, 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule